// File: doc/BRIEF.md
# Throttle-Aware 3D Route Candidate Generator

This block is the routing function of one router in a stacked mesh of layers. It is purely combinational. From the router's own coordinates, the packet's destination coordinates and the direction the packet was travelling when it came in, it produces a six-bit set of output directions that the packet may legally take next. A separate selector, outside this block, picks one direction from that set. Every direction in the set moves the packet one hop closer to its destination and respects a turn discipline, so that no cyclic channel dependency can form.

Inside a layer the block applies the odd-even turn model. Between layers it favours moving down. Moving up is reserved for a packet that already sits directly below its destination. A throttle map for the router's current layer marks nodes that thermal management has idled. Only the nodes in the minimal rectangle between the router and the destination are examined. The result of that examination selects one of four modes:

- `MODE_DELIVER`: the packet is at its destination.
- `MODE_COLUMN`: the planar coordinates already match, so only a vertical move remains.
- `MODE_OPEN`: the minimal rectangle holds no throttled node. The full odd-even set is offered, plus Down when the destination is lower.
- `MODE_DETOUR`: a throttled node lies in the rectangle. The packet stays in the layer and steers away from throttled neighbours.

Top module: `route_cand_gen`

## Requirements
- R1: When all three current coordinates equal the destination coordinates, `local_hit` is 1, `cand` is all zero and `stall` is 0. In every other case `local_hit` is 0.
- R2: The bits of `cand` are bit 0 North (y+1), bit 1 South (y-1), bit 2 East (x+1), bit 3 West (x-1), bit 4 Up (z+1) and bit 5 Down (z-1). A bit is set only if that move reduces the distance to the destination along its own axis.
- R3: When x and y match the destination and the destination layer is lower, `cand` is exactly Down, unless the packet arrived travelling Up. In that case `cand` is empty. Up and Down are never offered together.
- R4: Up is offered only when x and y match the destination, the destination layer is higher, and the packet was injected locally or arrived travelling Up. After a planar or a downward arrival, Up is never offered, and `cand` is then empty.
- R5: `in_arr` gives the direction of travel on arrival: 0 local injection, 1 North, 2 South, 3 East, 4 West, 5 Up, 6 Down; code 7 is treated as 0. In an even column, a packet that arrived travelling East gets neither North nor South. In an odd column, a packet that arrived travelling North or South never gets West. No direction that reverses the arrival direction is ever offered.
- R6: Planar candidates follow these rules, where parity is that of the x coordinate:
  - West is offered whenever the destination lies west.
  - When heading west, the needed North or South move is offered only in an even column.
  - When heading east, the needed North or South move is offered if the column is odd or the packet did not arrive travelling East.
  - East is offered when the destination lies east, unless the destination column is even, is one hop away, and the y coordinates differ.
  - When x already matches, the needed North or South move is offered.
  - The R5 filter is then applied.
- R7: With x,y differing and no throttled node in the minimal region, `cand` is the R6 planar set. Down is added when the destination layer is lower and the packet did not arrive travelling Up. `detour` is 0.
- R8: With x,y differing and a throttled node in the minimal region, `detour` is 1 and Down is withheld. Any planar candidate whose next node is throttled is removed. If that would remove all of them, the unfiltered planar set is given instead.
- R9: `hot_map` bit y*8+x marks node (x,y) of the current layer. The minimal region is the rectangle spanned by the current and destination x and y, excluding the current node. Throttle bits outside it have no effect on any output.
- R10: `stall` is 1 exactly when `local_hit` is 0 and `cand` is empty. For a locally injected packet `stall` is never 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_x | input | 3 | x coordinate of this router |
| cur_y | input | 3 | y coordinate of this router |
| cur_z | input | 2 | layer of this router, 0 at the bottom |
| dst_x | input | 3 | destination x |
| dst_y | input | 3 | destination y |
| dst_z | input | 2 | destination layer |
| in_arr | input | 3 | direction of travel on arrival (R5 codes) |
| hot_map | input | 64 | throttled-node flags for the current layer, bit y*8+x |
| cand | output | 6 | legal output directions (R2 bit order) |
| local_hit | output | 1 | packet has reached its destination |
| stall | output | 1 | no legal direction exists for this request |
| detour | output | 1 | a throttled node lies in the minimal region |

## Verification
The hardest state to reach is the detour fallback. It needs throttled nodes inside the minimal rectangle that also occupy every planar candidate's next hop, while the destination lies both diagonally away and in a lower layer. Random maps almost never produce this. Directed vectors therefore place throttled bits on exactly the west and south neighbours, and separately on interior and outside-rectangle nodes, to separate R8 from R9. An exhaustive sweep over every coordinate pair, layer pair and arrival code, with sparse pseudo-random throttle maps, covers the forbidden turns and the never-empty rule for local injection.

// File: rtl/route3d_pkg.sv
package route3d_pkg;

    // Direction of travel of a packet when it entered this router
    typedef enum logic [2:0] {
        ARR_LOCAL = 3'd0,
        ARR_NORTH = 3'd1,
        ARR_SOUTH = 3'd2,
        ARR_EAST  = 3'd3,
        ARR_WEST  = 3'd4,
        ARR_UP    = 3'd5,
        ARR_DOWN  = 3'd6,
        ARR_SPARE = 3'd7
    } arr_e;

    // Routing mode picked for the current request
    typedef enum logic [1:0] {
        MODE_DELIVER = 2'd0,
        MODE_COLUMN  = 2'd1,
        MODE_OPEN    = 2'd2,
        MODE_DETOUR  = 2'd3
    } mode_e;

    // Bit positions inside the candidate mask
    localparam int PN = 0;
    localparam int PS = 1;
    localparam int PE = 2;
    localparam int PW = 3;
    localparam int PU = 4;
    localparam int PD = 5;

    function automatic logic arr_planar(input arr_e a);
        return (a == ARR_NORTH) || (a == ARR_SOUTH) ||
               (a == ARR_EAST)  || (a == ARR_WEST);
    endfunction

endpackage

// File: rtl/route_hot_scan.sv
// Scans the minimal rectangle of the current layer for throttled nodes and
// reports the throttle state of the four planar neighbours.
module route_hot_scan #(
    parameter  int MX = 8,
    parameter  int MY = 8,
    localparam int XW = $clog2(MX),
    localparam int YW = $clog2(MY),
    localparam int NN = MX * MY,
    localparam int IW = $clog2(NN)
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic [NN-1:0] hot_map,
    output logic          hot_seen,
    output logic [3:0]    nbr_hot
);
    import route3d_pkg::*;

    logic [XW-1:0] x_lo, x_hi;
    logic [YW-1:0] y_lo, y_hi;
    logic [NN-1:0] in_box;

    always_comb begin
        x_lo = (cur_x < dst_x) ? cur_x : dst_x;
        x_hi = (cur_x < dst_x) ? dst_x : cur_x;
        y_lo = (cur_y < dst_y) ? cur_y : dst_y;
        y_hi = (cur_y < dst_y) ? dst_y : cur_y;
    end

    for (genvar gy = 0; gy < MY; gy++) begin : g_row
        for (genvar gx = 0; gx < MX; gx++) begin : g_col
            localparam int IDX = gy * MX + gx;
            assign in_box[IDX] = (XW'(gx) >= x_lo) && (XW'(gx) <= x_hi) &&
                                 (YW'(gy) >= y_lo) && (YW'(gy) <= y_hi) &&
                                 !((XW'(gx) == cur_x) && (YW'(gy) == cur_y));
        end
    end

    assign hot_seen = |(in_box & hot_map);

    function automatic logic node_hot(input logic [NN-1:0] map,
                                      input int x, input int y);
        if (x < 0 || x >= MX || y < 0 || y >= MY) return 1'b0;
        return map[IW'(y * MX + x)];
    endfunction

    int cx, cy;
    always_comb begin
        cx = int'(cur_x);
        cy = int'(cur_y);
        nbr_hot[PN] = node_hot(hot_map, cx,     cy + 1);
        nbr_hot[PS] = node_hot(hot_map, cx,     cy - 1);
        nbr_hot[PE] = node_hot(hot_map, cx + 1, cy);
        nbr_hot[PW] = node_hot(hot_map, cx - 1, cy);
    end

endmodule

// File: rtl/route_oe_planar.sv
// Odd-even turn-model candidates within one layer, minimal moves only.
module route_oe_planar #(
    parameter  int MX = 8,
    parameter  int MY = 8,
    localparam int XW = $clog2(MX),
    localparam int YW = $clog2(MY)
) (
    input  logic [XW-1:0]      cur_x,
    input  logic [YW-1:0]      cur_y,
    input  logic [XW-1:0]      dst_x,
    input  logic [YW-1:0]      dst_y,
    input  route3d_pkg::arr_e  arr,
    output logic [3:0]         pl
);
    import route3d_pkg::*;

    logic go_n, go_s, go_e, go_w;
    logic odd_c, odd_d, one_step;
    logic ns_ok, e_ok;
    logic [3:0] raw, keep;

    always_comb begin
        go_n     = dst_y > cur_y;
        go_s     = dst_y < cur_y;
        go_e     = dst_x > cur_x;
        go_w     = dst_x < cur_x;
        odd_c    = cur_x[0];
        odd_d    = dst_x[0];
        one_step = (dst_x - cur_x) == XW'(1);

        // Vertical-in-plane moves while the x offset is still open
        if (go_w)      ns_ok = !odd_c;
        else if (go_e) ns_ok = odd_c || (arr != ARR_EAST);
        else           ns_ok = 1'b1;

        // Never enter an even destination column eastbound with y left to do
        e_ok = !(go_n || go_s) || odd_d || !one_step;

        raw     = '0;
        raw[PN] = go_n && ns_ok;
        raw[PS] = go_s && ns_ok;
        raw[PE] = go_e && e_ok;
        raw[PW] = go_w;

        // Turn filter: forbidden odd-even turns and reversals
        keep = '1;
        if ((arr == ARR_EAST) && !odd_c) begin
            keep[PN] = 1'b0;
            keep[PS] = 1'b0;
        end
        if (((arr == ARR_NORTH) || (arr == ARR_SOUTH)) && odd_c) keep[PW] = 1'b0;
        if (arr == ARR_NORTH) keep[PS] = 1'b0;
        if (arr == ARR_SOUTH) keep[PN] = 1'b0;
        if (arr == ARR_EAST)  keep[PW] = 1'b0;
        if (arr == ARR_WEST)  keep[PE] = 1'b0;

        pl = raw & keep;
    end

endmodule

// File: rtl/route_cand_gen.sv
// Routing candidate generator for one router of a layered mesh.
module route_cand_gen #(
    parameter  int MX = 8,
    parameter  int MY = 8,
    parameter  int MZ = 4,
    localparam int XW = $clog2(MX),
    localparam int YW = $clog2(MY),
    localparam int ZW = $clog2(MZ),
    localparam int NN = MX * MY
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [ZW-1:0] cur_z,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic [ZW-1:0] dst_z,
    input  logic [2:0]    in_arr,
    input  logic [NN-1:0] hot_map,
    output logic [5:0]    cand,
    output logic          local_hit,
    output logic          stall,
    output logic          detour
);
    import route3d_pkg::*;

    arr_e       arr;
    mode_e      mode;
    logic       xy_eq, go_dn, go_up, hot_seen;
    logic [3:0] nbr_hot, pl, pl_safe;

    assign arr = (in_arr == 3'd7) ? ARR_LOCAL : arr_e'(in_arr);

    route_hot_scan #(.MX(MX), .MY(MY)) u_scan (
        .cur_x   (cur_x),
        .cur_y   (cur_y),
        .dst_x   (dst_x),
        .dst_y   (dst_y),
        .hot_map (hot_map),
        .hot_seen(hot_seen),
        .nbr_hot (nbr_hot)
    );

    route_oe_planar #(.MX(MX), .MY(MY)) u_oe (
        .cur_x(cur_x),
        .cur_y(cur_y),
        .dst_x(dst_x),
        .dst_y(dst_y),
        .arr  (arr),
        .pl   (pl)
    );

    // Mode decision
    always_comb begin
        xy_eq = (cur_x == dst_x) && (cur_y == dst_y);
        go_dn = dst_z < cur_z;
        go_up = dst_z > cur_z;
        if (xy_eq && !go_dn && !go_up) mode = MODE_DELIVER;
        else if (xy_eq)                mode = MODE_COLUMN;
        else if (hot_seen)             mode = MODE_DETOUR;
        else                           mode = MODE_OPEN;
    end

    assign pl_safe = pl & ~nbr_hot;

    // Outputs per mode
    always_comb begin
        cand = '0;
        unique case (mode)
            MODE_DELIVER: cand = '0;
            MODE_COLUMN: begin
                if (go_dn) cand[PD] = (arr != ARR_UP);
                else       cand[PU] = (arr == ARR_LOCAL) || (arr == ARR_UP);
            end
            MODE_OPEN: begin
                cand[3:0] = pl;
                cand[PD]  = go_dn && (arr != ARR_UP);
            end
            MODE_DETOUR: begin
                cand[3:0] = (pl_safe != 4'd0) ? pl_safe : pl;
            end
        endcase
    end

    assign local_hit = (mode == MODE_DELIVER);
    assign stall     = (mode != MODE_DELIVER) && (cand == 6'd0);
    assign detour    = (mode == MODE_DETOUR);

endmodule

// File: rtl/route_cand_chk.sv
// Checker bound to the candidate generator.
module route_cand_chk #(
    parameter  int MX = 8,
    parameter  int MY = 8,
    parameter  int MZ = 4,
    localparam int XW = $clog2(MX),
    localparam int YW = $clog2(MY),
    localparam int ZW = $clog2(MZ),
    localparam int NN = MX * MY
) (
    input logic [XW-1:0] cur_x,
    input logic [YW-1:0] cur_y,
    input logic [ZW-1:0] cur_z,
    input logic [XW-1:0] dst_x,
    input logic [YW-1:0] dst_y,
    input logic [ZW-1:0] dst_z,
    input logic [2:0]    in_arr,
    input logic [NN-1:0] hot_map,
    input logic [5:0]    cand,
    input logic          local_hit,
    input logic          stall,
    input logic          detour
);
    import route3d_pkg::*;

    logic same_xy, same_all, planar_in;

    always_comb begin
        same_xy   = (cur_x == dst_x) && (cur_y == dst_y);
        same_all  = same_xy && (cur_z == dst_z);
        planar_in = (in_arr >= 3'd1) && (in_arr <= 3'd4);
        if (!$isunknown({cur_x, cur_y, cur_z, dst_x, dst_y, dst_z, in_arr,
                         hot_map, cand, local_hit, stall, detour})) begin
            assert_deliver_R1: assert (local_hit == same_all &&
                                       (!local_hit || (cand == 6'd0 && !stall)))
                else $error("deliver rule broken");
            assert_minimal_R2: assert ((!cand[PN] || dst_y > cur_y) &&
                                       (!cand[PS] || dst_y < cur_y) &&
                                       (!cand[PE] || dst_x > cur_x) &&
                                       (!cand[PW] || dst_x < cur_x) &&
                                       (!cand[PU] || dst_z > cur_z) &&
                                       (!cand[PD] || dst_z < cur_z))
                else $error("non-minimal candidate");
            assert_one_vertical_R3: assert ($onehot0(cand[5:4]))
                else $error("up and down together");
            assert_up_gate_R4: assert (!cand[PU] ||
                                       (same_xy && !planar_in && in_arr != 3'd6))
                else $error("illegal up");
            assert_even_turn_R5: assert (!(in_arr == 3'd3 && !cur_x[0]) ||
                                         (!cand[PN] && !cand[PS]))
                else $error("east to north/south in even column");
            assert_odd_turn_R5: assert (!((in_arr == 3'd1 || in_arr == 3'd2) && cur_x[0]) ||
                                        !cand[PW])
                else $error("north/south to west in odd column");
            assert_detour_R8: assert (!detour || (!same_xy && !cand[PD] && !cand[PU]))
                else $error("detour mode with vertical move");
            assert_cold_map_R9: assert (hot_map != '0 || !detour)
                else $error("detour without any throttled node");
            assert_stall_R10: assert (stall == (!local_hit && cand == 6'd0) &&
                                      !((in_arr == 3'd0) && stall))
                else $error("stall rule broken");
        end
    end

endmodule

bind route_cand_gen route_cand_chk #(.MX(MX), .MY(MY), .MZ(MZ)) u_chk (
    .cur_x    (cur_x),
    .cur_y    (cur_y),
    .cur_z    (cur_z),
    .dst_x    (dst_x),
    .dst_y    (dst_y),
    .dst_z    (dst_z),
    .in_arr   (in_arr),
    .hot_map  (hot_map),
    .cand     (cand),
    .local_hit(local_hit),
    .stall    (stall),
    .detour   (detour)
);

// File: tb/sim_route_cand_gen.sv
`timescale 1ns/1ps
module sim_route_cand_gen;

    localparam int MX = 8;
    localparam int MY = 8;
    localparam int MZ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [2:0]  cur_x, cur_y, dst_x, dst_y, in_arr;
    logic [1:0]  cur_z, dst_z;
    logic [63:0] hot_map;
    logic [5:0]  cand;
    logic        local_hit, stall, detour;

    route_cand_gen #(.MX(MX), .MY(MY), .MZ(MZ)) u0 (
        .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
        .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
        .in_arr(in_arr), .hot_map(hot_map),
        .cand(cand), .local_hit(local_hit), .stall(stall), .detour(detour)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            n_vec++;
            $display("FAIL R10 watchdog: actual %0d cycles, expected fewer than 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Expected result {detour, stall, local_hit, cand} from the requirements
    function automatic logic [8:0] expect_out(int cx, int cy, int cz, int dx, int dy,
                                              int dz, int arr_in, logic [63:0] hm);
        int a;
        logic [5:0] m;
        logic [3:0] p, nb, f;
        bit hs, codd, dodd, vok, eok;
        int lox, hix, loy, hiy;
        a = (arr_in == 7) ? 0 : arr_in;
        m = '0;
        if (cx == dx && cy == dy && cz == dz) return {1'b0, 1'b0, 1'b1, 6'd0};   // R1
        if (cx == dx && cy == dy) begin                                          // R3, R4
            if (dz < cz && a != 5) m[5] = 1'b1;
            if (dz > cz && (a == 0 || a == 5)) m[4] = 1'b1;
            return {1'b0, (m == 6'd0), 1'b0, m};
        end
        // R9 region scan
        lox = (cx < dx) ? cx : dx;  hix = (cx < dx) ? dx : cx;
        loy = (cy < dy) ? cy : dy;  hiy = (cy < dy) ? dy : cy;
        hs = 0;
        for (int yy = loy; yy <= hiy; yy++)
            for (int xx = lox; xx <= hix; xx++)
                if (!(xx == cx && yy == cy) && hm[yy*8+xx]) hs = 1;
        // R6 planar rules
        codd = (cx % 2) == 1;
        dodd = (dx % 2) == 1;
        if (dx < cx)      vok = !codd;
        else if (dx > cx) vok = codd || (a != 3);
        else              vok = 1;
        eok = (cy == dy) || dodd || ((dx - cx) != 1);
        p = {dx < cx, (dx > cx) && eok, (dy < cy) && vok, (dy > cy) && vok};
        // R5 filter
        if (a == 3 && !codd) p[1:0] = 2'b00;
        if ((a == 1 || a == 2) && codd) p[3] = 1'b0;
        if (a == 1) p[1] = 1'b0;
        if (a == 2) p[0] = 1'b0;
        if (a == 3) p[3] = 1'b0;
        if (a == 4) p[2] = 1'b0;
        nb[0] = (cy + 1 < 8) ? hm[(cy+1)*8+cx] : 1'b0;
        nb[1] = (cy - 1 >= 0) ? hm[(cy-1)*8+cx] : 1'b0;
        nb[2] = (cx + 1 < 8) ? hm[cy*8+cx+1] : 1'b0;
        nb[3] = (cx - 1 >= 0) ? hm[cy*8+cx-1] : 1'b0;
        if (!hs) begin                                                           // R7
            m[3:0] = p;
            m[5]   = (dz < cz) && (a != 5);
        end else begin                                                           // R8
            f = p & ~nb;
            m[3:0] = (f != 4'd0) ? f : p;
        end
        return {hs, (m == 6'd0), 1'b0, m};
    endfunction

    task automatic compare(input logic [8:0] exp, input string tag);
        logic [8:0] act;
        act = {detour, stall, local_hit, cand};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cur=(%0d,%0d,%0d) dst=(%0d,%0d,%0d) arr=%0d: actual %b expected %b",
                     tag, cur_x, cur_y, cur_z, dst_x, dst_y, dst_z, in_arr, act, exp);
        end
    endtask

    typedef struct packed {
        logic [2:0]  cx, cy;
        logic [1:0]  cz;
        logic [2:0]  dx, dy;
        logic [1:0]  dz;
        logic [2:0]  arr;
        logic [63:0] hot;
        logic [5:0]  cand;
        logic        loc, stl, det;
        logic [3:0]  req;
    } tv_t;

    localparam int NT = 16;
    localparam tv_t TBL [NT] = '{
        '{3'd3,3'd4,2'd2, 3'd3,3'd4,2'd2, 3'd0, 64'h0,                  6'b000000, 1'b1,1'b0,1'b0, 4'd1},  // R1
        '{3'd2,3'd2,2'd3, 3'd2,3'd2,2'd0, 3'd3, 64'h0,                  6'b100000, 1'b0,1'b0,1'b0, 4'd3},  // R3
        '{3'd2,3'd2,2'd1, 3'd2,3'd2,2'd3, 3'd0, 64'h0,                  6'b010000, 1'b0,1'b0,1'b0, 4'd4},  // R4
        '{3'd2,3'd2,2'd1, 3'd2,3'd2,2'd3, 3'd1, 64'h0,                  6'b000000, 1'b0,1'b1,1'b0, 4'd4},  // R4
        '{3'd2,3'd1,2'd0, 3'd5,3'd4,2'd0, 3'd0, 64'h0,                  6'b000101, 1'b0,1'b0,1'b0, 4'd6},  // R6
        '{3'd2,3'd1,2'd0, 3'd5,3'd4,2'd0, 3'd3, 64'h0,                  6'b000100, 1'b0,1'b0,1'b0, 4'd5},  // R5
        '{3'd3,3'd1,2'd0, 3'd4,3'd5,2'd0, 3'd3, 64'h0,                  6'b000001, 1'b0,1'b0,1'b0, 4'd6},  // R6
        '{3'd5,3'd2,2'd1, 3'd1,3'd6,2'd1, 3'd0, 64'h0,                  6'b001000, 1'b0,1'b0,1'b0, 4'd6},  // R6
        '{3'd4,3'd2,2'd1, 3'd1,3'd6,2'd1, 3'd0, 64'h0,                  6'b001001, 1'b0,1'b0,1'b0, 4'd6},  // R6
        '{3'd4,3'd6,2'd3, 3'd1,3'd2,2'd0, 3'd0, 64'h0,                  6'b101010, 1'b0,1'b0,1'b0, 4'd7},  // R7
        '{3'd4,3'd6,2'd3, 3'd1,3'd2,2'd0, 3'd0, 64'h0008_0000_0000_0000, 6'b000010, 1'b0,1'b0,1'b1, 4'd8},  // R8
        '{3'd4,3'd6,2'd3, 3'd1,3'd2,2'd0, 3'd0, 64'h0008_1000_0000_0000, 6'b001010, 1'b0,1'b0,1'b1, 4'd8},  // R8 fallback
        '{3'd4,3'd6,2'd3, 3'd1,3'd2,2'd0, 3'd0, 64'h0020_0000_0000_0001, 6'b101010, 1'b0,1'b0,1'b0, 4'd9},  // R9 outside
        '{3'd4,3'd6,2'd3, 3'd1,3'd2,2'd0, 3'd0, 64'h0000_0004_0000_0000, 6'b001010, 1'b0,1'b0,1'b1, 4'd9},  // R9 interior
        '{3'd3,3'd2,2'd0, 3'd1,3'd5,2'd0, 3'd1, 64'h0,                  6'b000000, 1'b0,1'b1,1'b0, 4'd5},  // R5 odd turn
        '{3'd2,3'd2,2'd2, 3'd2,3'd2,2'd0, 3'd5, 64'h0,                  6'b000000, 1'b0,1'b1,1'b0, 4'd3}   // R3 reversal
    };

    function automatic logic [63:0] xs64(input logic [63:0] s);
        logic [63:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 7);
        v = v ^ (v << 17);
        return v;
    endfunction

    initial begin
        logic [63:0] seed;
        logic [63:0] r1, r2, r3;
        seed = 64'h9E37_79B9_7F4A_7C15;
        {cur_x, cur_y, cur_z, dst_x, dst_y, dst_z, in_arr} = '0;
        hot_map = '0;
        #25;
        // Reset state: all-zero request is a local delivery (R1)
        compare({1'b0, 1'b0, 1'b1, 6'd0}, "R1 reset");
        rst_n = 1'b1;
        #2;

        // Directed vector table
        for (int i = 0; i < NT; i++) begin
            cur_x = TBL[i].cx; cur_y = TBL[i].cy; cur_z = TBL[i].cz;
            dst_x = TBL[i].dx; dst_y = TBL[i].dy; dst_z = TBL[i].dz;
            in_arr = TBL[i].arr; hot_map = TBL[i].hot;
            #2;
            compare({TBL[i].det, TBL[i].stl, TBL[i].loc, TBL[i].cand},
                    $sformatf("R%0d table[%0d]", TBL[i].req, i));
        end

        // Spare arrival code behaves as local injection (R5)
        cur_x = 3'd2; cur_y = 3'd2; cur_z = 2'd1;
        dst_x = 3'd2; dst_y = 3'd2; dst_z = 2'd3; in_arr = 3'd7; hot_map = '0;
        #2;
        compare({1'b0, 1'b0, 1'b0, 6'b010000}, "R5 spare code");

        // Exhaustive sweep with sparse throttle maps
        for (int cz = 0; cz < MZ; cz++)
          for (int dz = 0; dz < MZ; dz++)
            for (int cy = 0; cy < MY; cy++)
              for (int cx = 0; cx < MX; cx++)
                for (int dy = 0; dy < MY; dy++)
                  for (int dx = 0; dx < MX; dx++)
                    for (int a = 0; a < 7; a++) begin
                        r1 = xs64(seed); r2 = xs64(r1); r3 = xs64(r2); seed = r3;
                        cur_x = 3'(cx); cur_y = 3'(cy); cur_z = 2'(cz);
                        dst_x = 3'(dx); dst_y = 3'(dy); dst_z = 2'(dz);
                        in_arr = 3'(a); hot_map = r1 & r2 & r3;
                        #2;
                        compare(expect_out(cx, cy, cz, dx, dy, dz, a, r1 & r2 & r3),
                                "R2 R6 R7 R8 sweep");
                        // R5: forbidden turns never offered
                        if (((a == 3) && (cx % 2 == 0) && (cand[1:0] != 2'b00)) ||
                            ((a == 1 || a == 2) && (cx % 2 == 1) && cand[3])) begin
                            n_bad++;
                            $display("FAIL R5 forbidden turn: actual %b expected no such turn", cand);
                        end
                        // R10: local injection always has a move
                        if (a == 0 && !local_hit && cand == 6'd0) begin
                            n_bad++;
                            $display("FAIL R10 empty set for injection: actual %b expected nonzero", cand);
                        end
                        n_vec += 2;
                    end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule